// File: doc/BRIEF.md
# Two-Pin External Interrupt Sense Unit

This block turns two asynchronous request pins into interrupt requests. Each pin has its own 2-bit sense mode. A mode selects one of four conditions: low level, any change, falling edge or rising edge. Each pin is first resampled on the I/O clock. In the three edge-type modes a detected transition latches a per-pin pending flag. Software or the interrupt dispatcher then clears that flag. In low-level mode no flag is latched: the request simply follows the pin while it stays low.

A request leaves the block on `irq_o` only when three conditions hold together: the pin's pending condition, the pin's mask bit and the global enable. The control fields and masks are loaded by whole-word writes. The pending flags are cleared by a write-one-to-clear port or by a per-pin acknowledge from the dispatcher. All three registers are visible on output ports.

Top module: `eirq_sense_unit`

## Requirements
- R1: While reset is held and after it is released, `ctrl_o`, `mask_o`, `flag_o` and `irq_o` are all zero.
- R2: With a pin's sense field at 2'b11, a low-to-high transition sets its flag, and a high-to-low transition does not.
- R3: With a pin's sense field at 2'b10, a high-to-low transition sets its flag, and a low-to-high transition does not.
- R4: With a pin's sense field at 2'b01, a transition in either direction sets its flag, and a steady pin does not.
- R5: With a pin's sense field at 2'b00, its flag bit always reads zero, including a flag that was set before the mode changed. Its pending condition is the resynchronised pin being low.
- R6: `irq_o[n]` is one only when pin n's pending condition, `mask_o[n]` and `gie_i` are all one. Gating the request leaves the flag unchanged.
- R7: A cycle with `flag_wr_i` high clears every flag whose bit in `flag_wdata_i` is one. Flags whose write bit is zero are left alone.
- R8: `ack_i[n]` high for one cycle clears flag n.
- R9: When a clear (by write or by acknowledge) and a new qualifying event on the same pin fall in the same cycle, the flag ends up set.
- R10: A pin level change made between clock edges shows on `flag_o` after the third rising edge that sees the new level, and not after the first or second.
- R11: The two pins are independent: pin n's field sits at `ctrl_o[2n+1:2n]`, and an event on one pin sets only that pin's flag.
- R12: A write with `ctrl_we_i` or `mask_we_i` loads the whole word, which reads back on `ctrl_o` or `mask_o` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous request pins |
| gie_i | input | 1 | Global interrupt enable |
| ctrl_we_i | input | 1 | Load sense-control word |
| ctrl_wdata_i | input | 2*NUM_PINS | New sense fields, pin n at bits 2n+1:2n |
| mask_we_i | input | 1 | Load mask word |
| mask_wdata_i | input | NUM_PINS | New mask bits |
| flag_wr_i | input | 1 | Write-one-to-clear strobe for flags |
| flag_wdata_i | input | NUM_PINS | Ones select flags to clear |
| ack_i | input | NUM_PINS | Dispatcher acknowledge, clears a flag |
| ctrl_o | output | 2*NUM_PINS | Current sense fields |
| mask_o | output | NUM_PINS | Current mask bits |
| flag_o | output | NUM_PINS | Pending flags, zero in low-level mode |
| irq_o | output | NUM_PINS | Gated interrupt requests |

## Verification
The assertions assume the pins are held high through reset. The synchroniser and history flops reset high, so a low pin at release would count as a falling edge. They also assume that a sense-field write is the only way a flag can vanish without a clear. For that reason the "event wins" property excludes cycles with a control write. The stimulus keeps both pins high during reset. It changes pins only on falling clock edges and holds every level for several cycles, so no pulse is shorter than a clock period.

// File: rtl/eirq_pkg.sv
// Shared types and helpers for the external interrupt sense unit.
// Assumes sense fields are 2 bits wide; the encoding is fixed by software.
package eirq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_t;

    localparam int SENSE_W = 2;

    // Decide whether a sample pair counts as an event for the given mode.
    function automatic logic sense_fires(sense_t mode, logic cur, logic prev);
        logic hit;
        unique case (mode)
            SENSE_ANY:  hit = cur ^ prev;
            SENSE_FALL: hit = prev & ~cur;
            SENSE_RISE: hit = cur & ~prev;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/eirq_sync.sv
// Multi-stage resynchroniser for a vector of asynchronous pins.
// Assumes STAGES >= 2; every stage resets to RST_VAL (idle level).
module eirq_sync #(
    parameter int   WIDTH   = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= {WIDTH{RST_VAL}};
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                // Later stages let a metastable sample settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/eirq_detect.sv
// Per-pin event detector: keeps the previous synchronised sample and
// qualifies transitions by each pin's sense mode.
// Assumes the samples are already synchronous to clk.
module eirq_detect
    import eirq_pkg::*;
#(
    parameter int NUM_PINS = 2,
    localparam int CW      = NUM_PINS * SENSE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] smp_i,
    input  logic [CW-1:0]       mode_i,
    output logic [NUM_PINS-1:0] evt_o,
    output logic [NUM_PINS-1:0] lvl_mode_o,
    output logic [NUM_PINS-1:0] low_o
);

    logic [NUM_PINS-1:0] prev_q;

    // Remember the last sample so edges show as a difference.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= smp_i;
    end

    genvar i;
    generate
        for (i = 0; i < NUM_PINS; i++) begin : g_pin
            sense_t mode;
            // Decode this pin's field and qualify its event.
            always_comb begin
                mode          = sense_t'(mode_i[SENSE_W*i +: SENSE_W]);
                evt_o[i]      = sense_fires(mode, smp_i[i], prev_q[i]);
                lvl_mode_o[i] = (mode == SENSE_LOW);
                low_o[i]      = ~smp_i[i];
            end
        end
    endgenerate

endmodule

// File: rtl/eirq_flag.sv
// Pending-flag bank: set by qualified events, cleared by write-one or
// acknowledge, held at zero in level mode. A set beats a clear.
module eirq_flag #(
    parameter int NUM_PINS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] evt_i,
    input  logic [NUM_PINS-1:0] clr_i,
    input  logic [NUM_PINS-1:0] lvl_mode_i,
    output logic [NUM_PINS-1:0] flag_o
);

    logic [NUM_PINS-1:0] flag_q;

    genvar i;
    generate
        for (i = 0; i < NUM_PINS; i++) begin : g_flag
            // Apply the flag priority: level mode, then set, then clear.
            always_ff @(posedge clk) begin
                if (!rst_n)             flag_q[i] <= 1'b0;
                else if (lvl_mode_i[i]) flag_q[i] <= 1'b0;
                else if (evt_i[i])      flag_q[i] <= 1'b1;
                else if (clr_i[i])      flag_q[i] <= 1'b0;
            end
        end
    endgenerate

    // Reads are forced to zero while the pin is in level mode.
    assign flag_o = flag_q & ~lvl_mode_i;

endmodule

// File: rtl/eirq_sense_unit.sv
// Top of the external interrupt sense unit: control and mask registers,
// pin resynchronisation, event detection, pending flags, request gating.
// Assumes pins are held at their idle (high) level during reset.
module eirq_sense_unit
    import eirq_pkg::*;
#(
    parameter int NUM_PINS    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = NUM_PINS * SENSE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                gie_i,
    input  logic                ctrl_we_i,
    input  logic [CW-1:0]       ctrl_wdata_i,
    input  logic                mask_we_i,
    input  logic [NUM_PINS-1:0] mask_wdata_i,
    input  logic                flag_wr_i,
    input  logic [NUM_PINS-1:0] flag_wdata_i,
    input  logic [NUM_PINS-1:0] ack_i,
    output logic [CW-1:0]       ctrl_o,
    output logic [NUM_PINS-1:0] mask_o,
    output logic [NUM_PINS-1:0] flag_o,
    output logic [NUM_PINS-1:0] irq_o
);

    logic [CW-1:0]       ctrl_q;
    logic [NUM_PINS-1:0] mask_q;
    logic [NUM_PINS-1:0] smp_w;
    logic [NUM_PINS-1:0] evt_w;
    logic [NUM_PINS-1:0] lvl_w;
    logic [NUM_PINS-1:0] low_w;
    logic [NUM_PINS-1:0] clr_w;
    logic [NUM_PINS-1:0] flag_w;
    logic [NUM_PINS-1:0] pend_w;

    // Hold the sense-control word.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
    end

    // Hold the per-pin mask word.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_wdata_i;
    end

    eirq_sync #(
        .WIDTH   (NUM_PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (smp_w)
    );

    eirq_detect #(
        .NUM_PINS (NUM_PINS)
    ) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_i      (smp_w),
        .mode_i     (ctrl_q),
        .evt_o      (evt_w),
        .lvl_mode_o (lvl_w),
        .low_o      (low_w)
    );

    // Merge the two clear sources into one per-pin request.
    always_comb begin
        clr_w = ack_i | (flag_wdata_i & {NUM_PINS{flag_wr_i}});
    end

    eirq_flag #(
        .NUM_PINS (NUM_PINS)
    ) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_w),
        .clr_i      (clr_w),
        .lvl_mode_i (lvl_w),
        .flag_o     (flag_w)
    );

    // Pick the pending source per pin and gate it with mask and enable.
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            pend_w[i] = lvl_w[i] ? low_w[i] : flag_w[i];
        end
        irq_o = pend_w & mask_q & {NUM_PINS{gie_i}};
    end

    assign ctrl_o = ctrl_q;
    assign mask_o = mask_q;
    assign flag_o = flag_w;

endmodule

// File: rtl/eirq_sense_chk.sv
// Property checker for eirq_sense_unit; attached by the bind below.
// Assumes pins idle high during reset.
module eirq_sense_chk #(
    parameter int NUM_PINS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  gie_i,
    input logic                  ctrl_we_i,
    input logic                  flag_wr_i,
    input logic [NUM_PINS-1:0]   flag_wdata_i,
    input logic [NUM_PINS-1:0]   ack_i,
    input logic [2*NUM_PINS-1:0] ctrl_o,
    input logic [NUM_PINS-1:0]   mask_o,
    input logic [NUM_PINS-1:0]   flag_o,
    input logic [NUM_PINS-1:0]   irq_o,
    input logic [NUM_PINS-1:0]   evt
);

    p_irq_needs_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |-> (irq_o == '0));

    genvar i;
    generate
        for (i = 0; i < NUM_PINS; i++) begin : g_pin
            p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
                irq_o[i] |-> mask_o[i]);

            p_lvl_flag_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_o[2*i +: 2] == 2'b00) |-> !flag_o[i]);

            p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_wr_i && flag_wdata_i[i] && !evt[i]) |=> !flag_o[i]);

            p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_i[i] && !evt[i]) |=> !flag_o[i]);

            p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (evt[i] && !ctrl_we_i) |=> flag_o[i]);

            p_flag_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag_o[i]) |-> $past(evt[i]));
        end
    endgenerate

endmodule

bind eirq_sense_unit eirq_sense_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gie_i        (gie_i),
    .ctrl_we_i    (ctrl_we_i),
    .flag_wr_i    (flag_wr_i),
    .flag_wdata_i (flag_wdata_i),
    .ack_i        (ack_i),
    .ctrl_o       (ctrl_o),
    .mask_o       (mask_o),
    .flag_o       (flag_o),
    .irq_o        (irq_o),
    .evt          (evt_w)
);

// File: tb/eirq_sense_unit_bench.sv
// Self-checking bench: a vector table of mode/transition cases, then
// directed tests for reset, gating, clearing, latency and priorities.
module eirq_sense_unit_bench;

    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin = '1;
    logic          gie = 1'b0;
    logic          ctrl_we = 1'b0;
    logic [2*NP-1:0] ctrl_wd = '0;
    logic          mask_we = 1'b0;
    logic [NP-1:0] mask_wd = '0;
    logic          flag_wr = 1'b0;
    logic [NP-1:0] flag_wd = '0;
    logic [NP-1:0] ack = '0;
    logic [2*NP-1:0] ctrl_o;
    logic [NP-1:0] mask_o;
    logic [NP-1:0] flag_o;
    logic [NP-1:0] irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    eirq_sense_unit u_eirq_sense_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (pin),
        .gie_i        (gie),
        .ctrl_we_i    (ctrl_we),
        .ctrl_wdata_i (ctrl_wd),
        .mask_we_i    (mask_we),
        .mask_wdata_i (mask_wd),
        .flag_wr_i    (flag_wr),
        .flag_wdata_i (flag_wd),
        .ack_i        (ack),
        .ctrl_o       (ctrl_o),
        .mask_o       (mask_o),
        .flag_o       (flag_o),
        .irq_o        (irq_o)
    );

    // Vector: [5:4] mode, [3] start level, [2] end level, [1] flag, [0] irq
    localparam int NV = 9;
    localparam logic [5:0] VEC [NV] = '{
        6'b11_01_11, 6'b11_10_00,
        6'b10_10_11, 6'b10_01_00,
        6'b01_01_11, 6'b01_10_11, 6'b01_11_00,
        6'b00_10_01, 6'b00_01_00
    };

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(logic [1:0] m);
        case (m)
            2'b11:   return "R2";
            2'b10:   return "R3";
            2'b01:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic wr_ctrl(logic [2*NP-1:0] v);
        ctrl_wd = v; ctrl_we = 1'b1; tick(); ctrl_we = 1'b0;
    endtask

    task automatic clear_all();
        flag_wd = '1; flag_wr = 1'b1; tick(); flag_wr = 1'b0; flag_wd = '0;
    endtask

    // Main stimulus sequence.
    initial begin
        tick(3);
        // R1: outputs during reset
        check("R1", "irq in reset", 8'(irq_o), 8'h0);
        check("R1", "flag in reset", 8'(flag_o), 8'h0);
        rst_n = 1'b1;
        tick();
        check("R1", "ctrl after reset", 8'(ctrl_o), 8'h0);
        check("R1", "mask after reset", 8'(mask_o), 8'h0);
        check("R1", "irq after reset", 8'(irq_o), 8'h0);

        // R12: register loads read back
        mask_wd = 2'b01; mask_we = 1'b1; tick(); mask_we = 1'b0;
        check("R12", "mask readback", 8'(mask_o), 8'h01);
        wr_ctrl(4'b1011);
        check("R12", "ctrl readback", 8'(ctrl_o), 8'h0b);
        gie = 1'b1;

        // Table walk on pin 0 (pin 1 kept steady high, mode 00 there).
        for (int v = 0; v < NV; v++) begin
            pin[0] = VEC[v][3];
            wr_ctrl({2'b00, VEC[v][5:4]});
            tick(4);
            clear_all();
            tick();
            pin[0] = VEC[v][2];
            tick(4);
            check(req_of(VEC[v][5:4]), $sformatf("flag vec %0d", v), 8'(flag_o[0]), 8'(VEC[v][1]));
            check(req_of(VEC[v][5:4]), $sformatf("irq vec %0d", v), 8'(irq_o[0]), 8'(VEC[v][0]));
        end

        // R5: flag set in edge mode reads zero once mode goes to 00
        pin[0] = 1'b1; wr_ctrl(4'b0010); tick(4); clear_all();
        pin[0] = 1'b0; tick(4);
        check("R5", "flag before mode change", 8'(flag_o[0]), 8'h1);
        wr_ctrl(4'b0000);
        check("R5", "flag hidden in level mode", 8'(flag_o[0]), 8'h0);
        check("R5", "irq low level", 8'(irq_o[0]), 8'h1);

        // R6: gating with mask and enable
        pin[0] = 1'b0; wr_ctrl(4'b0011); tick(4); clear_all();
        pin[0] = 1'b1; tick(4);
        mask_wd = 2'b00; mask_we = 1'b1; tick(); mask_we = 1'b0;
        check("R6", "irq masked", 8'(irq_o[0]), 8'h0);
        check("R6", "flag kept while masked", 8'(flag_o[0]), 8'h1);
        mask_wd = 2'b01; mask_we = 1'b1; gie = 1'b0; tick(); mask_we = 1'b0;
        check("R6", "irq without gie", 8'(irq_o[0]), 8'h0);
        gie = 1'b1; tick();
        check("R6", "irq all enabled", 8'(irq_o[0]), 8'h1);

        // R7: write-one-to-clear only affects selected bits
        flag_wd = 2'b10; flag_wr = 1'b1; tick(); flag_wr = 1'b0;
        check("R7", "zero bit leaves flag", 8'(flag_o[0]), 8'h1);
        flag_wd = 2'b01; flag_wr = 1'b1; tick(); flag_wr = 1'b0; flag_wd = '0;
        check("R7", "one bit clears flag", 8'(flag_o[0]), 8'h0);

        // R8: acknowledge clears
        pin[0] = 1'b0; tick(4); pin[0] = 1'b1; tick(4);
        check("R8", "flag before ack", 8'(flag_o[0]), 8'h1);
        ack = 2'b01; tick(); ack = '0;
        check("R8", "flag after ack", 8'(flag_o[0]), 8'h0);

        // R10: latency of three edges
        pin[0] = 1'b0; tick(4); clear_all();
        pin[0] = 1'b1;
        tick();
        check("R10", "flag after edge 1", 8'(flag_o[0]), 8'h0);
        tick();
        check("R10", "flag after edge 2", 8'(flag_o[0]), 8'h0);
        tick();
        check("R10", "flag after edge 3", 8'(flag_o[0]), 8'h1);

        // R9: clear and event in the same cycle, event wins
        pin[0] = 1'b0; tick(4); clear_all();
        pin[0] = 1'b1;
        tick(2);
        flag_wd = 2'b01; flag_wr = 1'b1; ack = 2'b01;
        tick();
        flag_wr = 1'b0; flag_wd = '0; ack = '0;
        check("R9", "set beats clear", 8'(flag_o[0]), 8'h1);

        // R11: independent pins, pin1 field at bits 3:2
        pin = 2'b01; wr_ctrl(4'b1110); tick(4); clear_all();
        pin = 2'b11; tick(4);
        check("R11", "only pin1 flag", 8'(flag_o), 8'h2);
        mask_wd = 2'b10; mask_we = 1'b1; tick(); mask_we = 1'b0;
        check("R11", "only pin1 irq", 8'(irq_o), 8'h2);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=timeout expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule